// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small programmable counter that is stepped by two independent strobe inputs. A rising edge on one strobe adds one to the count, and a rising edge on the other strobe subtracts one. The count can be preset from a parallel data word or cleared to zero. Clear wins over preset, and preset wins over counting. The whole block runs on a single system clock. Both strobes are synchronized to that clock and are edge-detected inside the block.

Two active-low lookahead outputs make wide counters simple to build. The carry output goes low while the count is at its maximum and the up strobe is low. The borrow output goes low while the count is zero and the down strobe is low. To cascade, feed the carry of one stage into the up strobe of the next stage, and feed the borrow into its down strobe. No glue logic is needed.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0, `carry_n` and `borrow_n` read 1, and both strobe histories are set to the high (idle) level.
- R2: A rising edge on `up_strobe` adds one to the count, provided the synchronized `down_strobe` is high, `clear` is low and `load_n` is high. The new count is visible two clock edges after the edge is sampled.
- R3: A rising edge on `down_strobe` subtracts one from the count, provided the synchronized `up_strobe` is high, `clear` is low and `load_n` is high.
- R4: The count wraps modulo 2^WIDTH in both directions. With the default WIDTH of 4, counting up from 15 gives 0 and counting down from 0 gives 15.
- R5: A clock edge with `clear` high sets the count to 0, whatever `load_n`, `preset_d` and the strobes are doing.
- R6: While `load_n` is low and `clear` is low, each clock edge copies `preset_d` into the count, so the count tracks the data word. Strobe edges that occur during the load are discarded.
- R7: `carry_n` is 0 exactly when the count is all ones and the synchronized up strobe is low. Otherwise it is 1.
- R8: `borrow_n` is 0 exactly when the count is zero and the synchronized down strobe is low. Otherwise it is 1.
- R9: A rising edge on one strobe while the other synchronized strobe is low leaves the count unchanged.
- R10: Rising edges seen on both strobes in the same cycle leave the count unchanged.
- R11: Two instances can be chained, with the upper stage's `up_strobe` driven by the lower stage's `carry_n` and its `down_strobe` by `borrow_n`. The pair then counts correctly as one 2*WIDTH-bit counter in both directions, including across the digit boundary.
- R12: Outside a clear or a load, the count moves by at most one step per clock edge, and all of its bits change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| up_strobe | input | 1 | Count-up strobe; acts on its rising edge |
| down_strobe | input | 1 | Count-down strobe; acts on its rising edge |
| load_n | input | 1 | Parallel preset enable, active low |
| clear | input | 1 | Synchronous clear, active high |
| preset_d | input | WIDTH | Parallel preset data |
| count_q | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal-count carry, active low |
| borrow_n | output | 1 | Zero-count borrow, active low |

## Verification
Some behaviours are checked by assertions on every cycle:
- the single-step increment and decrement on a qualified edge;
- the forced zero after a clear and the copy of the preset during a load;
- a count that holds when the other strobe is low or both edges arrive together;
- an edge pulse that never lasts two cycles in a row.

Other behaviours can only be shown by the bench's scenarios:
- the wrap in each direction;
- the exact cycles at which the active-low carry and borrow appear and disappear;
- discarding a strobe pulse that falls entirely inside a clear or a load;
- the two-stage chain stepping its upper digit up and down across the boundary.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Idle level of both strobe inputs: strobes rest high.
    localparam logic STROBE_IDLE = 1'b1;

    // Synchronized view of one strobe.
    typedef struct packed {
        logic level;  // synchronized level
        logic rise;   // one-cycle pulse on a 0 -> 1 transition
    } strobe_t;

    // Action the counter takes at the next clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_STEP  = 2'd3
    } act_e;

    // Direction of a qualified step.
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    // Priority decode: clear, then load, then counting.
    function automatic act_e pick_action(input logic clr, input logic ld_n, input dir_e dir);
        if (clr)
            return ACT_CLEAR;
        else if (!ld_n)
            return ACT_LOAD;
        else if (dir != DIR_NONE)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

    // A step needs exactly one edge, and the opposite strobe must rest high.
    function automatic dir_e pick_dir(input strobe_t up, input strobe_t dn);
        if (up.rise && !dn.rise && dn.level)
            return DIR_UP;
        else if (dn.rise && !up.rise && up.level)
            return DIR_DOWN;
        else
            return DIR_NONE;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import dsc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    raw,
    output strobe_t strobe
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          hist;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= STROBE_IDLE;
                else     chain <= raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{STROBE_IDLE}};
                else     chain <= {chain[LAST-1:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hist <= STROBE_IDLE;
        else     hist <= chain[LAST];
    end

    assign strobe.level = chain[LAST];
    assign strobe.rise  = chain[LAST] & ~hist;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobe.rise |=> !strobe.rise); // R12

endmodule

// File: rtl/count_core.sv
module count_core
    import dsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_d,
    input  strobe_t          up,
    input  strobe_t          dn,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    dir_e             dir;
    act_e             act;
    logic [WIDTH-1:0] next_count;

    always_comb begin
        dir = pick_dir(up, dn);
        act = pick_action(clear, load_n, dir);
        unique case (act)
            ACT_CLEAR: next_count = '0;
            ACT_LOAD:  next_count = preset_d;
            ACT_STEP:  next_count = (dir == DIR_UP) ? count + ONE : count - ONE;
            default:   next_count = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= next_count;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == '0); // R5

    AST_LOAD_TRACK: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load_n) |=> count == $past(preset_d)); // R6

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clear && load_n && up.rise && !dn.rise && dn.level)
        |=> count == $past(count) + ONE); // R2

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clear && load_n && dn.rise && !up.rise && up.level)
        |=> count == $past(count) - ONE); // R3

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
        (!clear && load_n && ((up.rise && !dn.level) || (dn.rise && !up.level)))
        |=> $stable(count)); // R9

    AST_BOTH_EDGES: assert property (@(posedge clk) disable iff (rst)
        (!clear && load_n && up.rise && dn.rise) |=> $stable(count)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && load_n && !up.rise && !dn.rise) |=> $stable(count)); // R12

endmodule

// File: rtl/lookahead.sv
module lookahead #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_level,
    input  logic             dn_level,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    always_comb begin
        carry_n  = ~((count == TOP) & ~up_level);
        borrow_n = ~((count == '0)  & ~dn_level);
    end

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_strobe,
    input  logic             down_strobe,
    input  logic             load_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] preset_d,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_n,
    output logic             borrow_n
);
    strobe_t up_s;
    strobe_t dn_s;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (up_strobe),
        .strobe (up_s)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (down_strobe),
        .strobe (dn_s)
    );

    count_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .load_n   (load_n),
        .preset_d (preset_d),
        .up       (up_s),
        .dn       (dn_s),
        .count    (count_q)
    );

    lookahead #(.WIDTH(WIDTH)) u_look (
        .count    (count_q),
        .up_level (up_s.level),
        .dn_level (dn_s.level),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (count_q == '0 && carry_n && borrow_n)); // R1

endmodule

// File: tb/dual_strobe_counter_bench.sv
module dual_strobe_counter_bench;

    localparam int W = 4;

    typedef struct {
        string      tag;
        logic [W-1:0] q;
        logic       c;
        logic       b;
        bit         wide;
        logic [2*W-1:0] v;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up = 1'b1;
    logic dn = 1'b1;
    logic load_n = 1'b1;
    logic clear = 1'b0;
    logic [W-1:0] lo_d = '0;
    logic [W-1:0] hi_d = '0;

    logic [W-1:0] lo_q, hi_q;
    logic lo_c, lo_b, hi_c, hi_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    item_t sb[$];

    always #10 clk = ~clk;

    dual_strobe_counter #(.WIDTH(W)) u_dual_strobe_counter (
        .clk(clk), .rst(rst), .up_strobe(up), .down_strobe(dn),
        .load_n(load_n), .clear(clear), .preset_d(lo_d),
        .count_q(lo_q), .carry_n(lo_c), .borrow_n(lo_b)
    );

    dual_strobe_counter #(.WIDTH(W)) u_hi (
        .clk(clk), .rst(rst), .up_strobe(lo_c), .down_strobe(lo_b),
        .load_n(load_n), .clear(clear), .preset_d(hi_d),
        .count_q(hi_q), .carry_n(hi_c), .borrow_n(hi_b)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_lo(string tag, logic [W-1:0] q, logic c, logic b);
        item_t it;
        it.tag = tag; it.q = q; it.c = c; it.b = b; it.wide = 1'b0; it.v = '0;
        sb.push_back(it);
        tick(1);
    endtask

    task automatic expect_wide(string tag, logic [2*W-1:0] v);
        item_t it;
        it.tag = tag; it.q = v[W-1:0]; it.c = 1'b1; it.b = 1'b1; it.wide = 1'b1; it.v = v;
        sb.push_back(it);
        tick(1);
    endtask

    task automatic pulse_up();
        up = 1'b0; tick(4);
        up = 1'b1; tick(10);
    endtask

    task automatic pulse_dn();
        dn = 1'b0; tick(4);
        dn = 1'b1; tick(10);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (it.wide) begin
                    if ({hi_q, lo_q} !== it.v) begin
                        fails++;
                        $display("FAIL %s: count actual %0h expected %0h", it.tag, {hi_q, lo_q}, it.v);
                    end
                end else if (lo_q !== it.q || lo_c !== it.c || lo_b !== it.b) begin
                    fails++;
                    $display("FAIL %s: q/c/b actual %0d/%0b/%0b expected %0d/%0b/%0b",
                             it.tag, lo_q, lo_c, lo_b, it.q, it.c, it.b);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    // Driver
    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_lo("R1 reset state", 4'd0, 1'b1, 1'b1);

        // R8: borrow while zero and down held low
        dn = 1'b0; tick(4);
        expect_lo("R8 borrow low at zero", 4'd0, 1'b1, 1'b0);
        dn = 1'b1; tick(10);
        expect_lo("R4 wrap down 0->15", 4'd15, 1'b1, 1'b1);

        pulse_up();
        expect_lo("R4 wrap up 15->0", 4'd0, 1'b1, 1'b1);
        pulse_up(); expect_lo("R2 up 1", 4'd1, 1'b1, 1'b1);
        pulse_up(); expect_lo("R2 up 2", 4'd2, 1'b1, 1'b1);
        pulse_up(); expect_lo("R2 up 3", 4'd3, 1'b1, 1'b1);
        pulse_dn(); expect_lo("R3 down 2", 4'd2, 1'b1, 1'b1);

        // R9: up edge while down held low
        dn = 1'b0; tick(4);
        pulse_up();
        expect_lo("R9 up edge ignored with down low", 4'd2, 1'b1, 1'b1);
        dn = 1'b1; tick(10);
        expect_lo("R3 down release counts", 4'd1, 1'b1, 1'b1);

        // R10: simultaneous edges
        up = 1'b0; dn = 1'b0; tick(4);
        up = 1'b1; dn = 1'b1; tick(10);
        expect_lo("R10 both edges no change", 4'd1, 1'b1, 1'b1);

        // R6: load tracks data, strobes ignored
        lo_d = 4'd9; load_n = 1'b0; tick(3);
        expect_lo("R6 load 9", 4'd9, 1'b1, 1'b1);
        lo_d = 4'd5; tick(3);
        expect_lo("R6 load follows 5", 4'd5, 1'b1, 1'b1);
        pulse_up();
        expect_lo("R6 strobe ignored during load", 4'd5, 1'b1, 1'b1);
        load_n = 1'b1; tick(3);
        expect_lo("R6 after load release", 4'd5, 1'b1, 1'b1);

        // R7: carry at top with up low
        lo_d = 4'd15; load_n = 1'b0; tick(3);
        load_n = 1'b1; tick(3);
        expect_lo("R7 carry high while up high", 4'd15, 1'b1, 1'b1);
        up = 1'b0; tick(4);
        expect_lo("R7 carry low at top", 4'd15, 1'b0, 1'b1);
        up = 1'b1; tick(10);
        expect_lo("R4 wrap after carry", 4'd0, 1'b1, 1'b1);

        // R5: clear overrides load and strobes
        lo_d = 4'd7; load_n = 1'b0; clear = 1'b1; tick(3);
        expect_lo("R5 clear beats load", 4'd0, 1'b1, 1'b1);
        pulse_up();
        expect_lo("R5 strobe ignored during clear", 4'd0, 1'b1, 1'b1);
        load_n = 1'b1; clear = 1'b0; tick(3);
        expect_lo("R5 after clear release", 4'd0, 1'b1, 1'b1);

        // R11: two-stage cascade
        lo_d = 4'd14; hi_d = 4'd0; load_n = 1'b0; tick(3);
        load_n = 1'b1; tick(3);
        expect_wide("R11 cascade preset", 8'h0E);
        pulse_up(); expect_wide("R11 cascade up 0F", 8'h0F);
        pulse_up(); expect_wide("R11 cascade up 10", 8'h10);
        pulse_up(); expect_wide("R11 cascade up 11", 8'h11);
        pulse_dn(); expect_wide("R11 cascade down 10", 8'h10);
        pulse_dn(); expect_wide("R11 cascade down 0F", 8'h0F);
        pulse_dn(); expect_wide("R11 cascade down 0E", 8'h0E);

        tick(3);
        done = 1'b1;
        report();
    end

endmodule